// File: doc/BRIEF.md
# Configurable Polarity Interrupt Controller

This block gathers a word of interrupt request lines, one per source, and turns them into a latched status word and a single interrupt line. Each source has three control bits of its own: an enable (mask), a polarity and a sensitivity type. Together they pick one of four trigger modes: high level, low level, rising edge or falling edge. Every source input passes through a two-flop synchroniser before it is qualified. Level sources show their present qualified state in the raw status. Edge sources latch an event until software clears it by writing a 1 to that bit.

Software reaches the block through a flat register port with a word address, write data, a write strobe and a combinational read data path. Register selects: 0 enable mask, 1 polarity, 2 type, 3 raw status (reads give the latched state, written ones clear edge bits), 4 masked status (read only). The polarity and type registers reset to constants given as parameters, so each instance can start in its own trigger setup. The mask resets to all zeros. Two instances can be cascaded by wiring the interrupt output of one into a source input of another. The reset input is asynchronous and active low, and its release is expected to be synchronous to the clock.

Top module: `irq_polarity_ctrl`

## Requirements
- R1: After reset the mask reads 0, polarity reads the POL_RESET parameter, type reads the TYPE_RESET parameter, and with all inputs inactive the raw status, the masked status and irq_o are 0.
- R2: Writes to select 0 (mask), 1 (polarity) and 2 (type) with we_i high store wdata_i, and a read of the same select returns it.
- R3: For a source whose type bit is 0 (level), raw status bit n equals 1 exactly when src_i[n] equals polarity bit n (polarity 1 means active high, 0 means active low). The change becomes visible after the third rising clock edge following the input change.
- R4: For a source whose type bit is 1 (edge), a transition of src_i[n] into its active level sets raw status bit n: rising when polarity is 1, falling when polarity is 0. The bit stays set after the input returns to its inactive level.
- R5: Writing to select 3 clears every edge-mode raw bit whose wdata_i bit is 1. Zeros in the write data leave bits unchanged. A level-mode bit whose input is still active reads 1 after the write.
- R6: When an edge event and a clear of the same bit fall in the same clock cycle, the raw status bit stays set.
- R7: Select 4 returns the raw status ANDed with the mask, and a write to select 4 changes no register.
- R8: irq_o equals the OR of all masked status bits, delayed by one clock cycle.
- R9: A source with mask bit 0 still latches into the raw status but does not show in the masked status or on irq_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| src_i | input | NSRC (32) | Interrupt request lines, asynchronous to clk |
| addr_i | input | 3 | Register select |
| wdata_i | input | NSRC (32) | Write data |
| we_i | input | 1 | Write strobe, one write per cycle |
| rdata_o | output | NSRC (32) | Read data for addr_i, combinational |
| irq_o | output | 1 | Registered OR of the masked status |

## Verification
The embedded assertions check four things on every cycle for each bit: a level-mode raw bit tracks its qualified input, an edge-mode bit holds until cleared, a clear without a coincident event empties the bit, and a coincident event wins over the clear. They also check that irq_o is the one-cycle-delayed OR of the masked status, and that a clear pulse appears only on a write. The bench scenarios are needed for everything that involves the full path from the pins: synchroniser latency, rising against falling selection, reset defaults, register read-back, masking at select 4 and writes that must be ignored.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_MASK  = 3'd0,
    SEL_POL   = 3'd1,
    SEL_TYPE  = 3'd2,
    SEL_RAW   = 3'd3,
    SEL_MSTAT = 3'd4
  } irqc_sel_e;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_i;
      stage2_q <= stage1_q;
    end
  end

  assign sync_o = stage2_q;
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int unsigned         NSRC      = 32,
  parameter logic [NSRC-1:0]     POL_RESET = '0,
  parameter logic [NSRC-1:0]     TYPE_RESET = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] addr_i,
  input  logic [NSRC-1:0]  wdata_i,
  input  logic             we_i,
  output logic [NSRC-1:0]  mask_o,
  output logic [NSRC-1:0]  pol_o,
  output logic [NSRC-1:0]  type_o,
  output logic [NSRC-1:0]  clr_o
);
  logic            en_mask, en_pol, en_type;
  logic [NSRC-1:0] mask_q, pol_q, type_q;
  logic [NSRC-1:0] mask_d, pol_d, type_d;

  always_comb begin
    en_mask = 1'b0;
    en_pol  = 1'b0;
    en_type = 1'b0;
    clr_o   = '0;
    if (we_i) begin
      unique case (irqc_sel_e'(addr_i))
        SEL_MASK: en_mask = 1'b1;
        SEL_POL:  en_pol  = 1'b1;
        SEL_TYPE: en_type = 1'b1;
        SEL_RAW:  clr_o   = wdata_i;
        default:  ;
      endcase
    end
    mask_d = en_mask ? wdata_i : mask_q;
    pol_d  = en_pol  ? wdata_i : pol_q;
    type_d = en_type ? wdata_i : type_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      pol_q  <= POL_RESET;
      type_q <= TYPE_RESET;
    end else begin
      mask_q <= mask_d;
      pol_q  <= pol_d;
      type_q <= type_d;
    end
  end

  assign mask_o = mask_q;
  assign pol_o  = pol_q;
  assign type_o = type_q;

  AST_CLR_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_o != '0) |-> (we_i && addr_i == SEL_RAW)); // R5
endmodule

// File: rtl/irqc_detect.sv
module irqc_detect #(
  parameter int unsigned NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] lvl_i,
  input  logic [NSRC-1:0] pol_i,
  input  logic [NSRC-1:0] type_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] raw_o
);
  logic [NSRC-1:0] act, evt;
  logic [NSRC-1:0] prev_q, prev_d;
  logic [NSRC-1:0] raw_q, raw_d;

  always_comb begin
    act    = ~(lvl_i ^ pol_i);
    evt    = type_i & act & ~prev_q;
    prev_d = act;
    raw_d  = (type_i & (evt | (raw_q & ~clr_i))) | (~type_i & act);
  end

  // prev resets to all ones so no edge is seen before a real inactive sample
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '1;
      raw_q  <= '0;
    end else begin
      prev_q <= prev_d;
      raw_q  <= raw_d;
    end
  end

  assign raw_o = raw_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_chk
    AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      !type_i[i] |=> raw_q[i] == $past(lvl_i[i] == pol_i[i])); // R3
    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (type_i[i] && raw_q[i] && !clr_i[i]) |=> raw_q[i]); // R4
    AST_EDGE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (type_i[i] && clr_i[i] && !evt[i]) |=> !raw_q[i]); // R5
    AST_CLEAR_RACE: assert property (@(posedge clk) disable iff (!rst_n)
      (type_i[i] && clr_i[i] && evt[i]) |=> raw_q[i]); // R6
  end
endmodule

// File: rtl/irq_polarity_ctrl.sv
module irq_polarity_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned     NSRC       = 32,
  parameter logic [NSRC-1:0] POL_RESET  = 32'h3FF0_EFE0,
  parameter logic [NSRC-1:0] TYPE_RESET = 32'h0000_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_i,
  input  logic [SEL_W-1:0] addr_i,
  input  logic [NSRC-1:0]  wdata_i,
  input  logic             we_i,
  output logic [NSRC-1:0]  rdata_o,
  output logic             irq_o
);
  logic [NSRC-1:0] lvl, mask, pol, typ, clr, raw, mstat;
  logic            irq_q, irq_d;

  irqc_sync #(.W(NSRC)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(src_i), .sync_o(lvl)
  );

  irqc_regs #(.NSRC(NSRC), .POL_RESET(POL_RESET), .TYPE_RESET(TYPE_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wdata_i(wdata_i), .we_i(we_i),
    .mask_o(mask), .pol_o(pol), .type_o(typ), .clr_o(clr)
  );

  irqc_detect #(.NSRC(NSRC)) u_detect (
    .clk(clk), .rst_n(rst_n), .lvl_i(lvl), .pol_i(pol), .type_i(typ),
    .clr_i(clr), .raw_o(raw)
  );

  always_comb begin
    mstat = raw & mask;
    irq_d = |mstat;
    unique case (irqc_sel_e'(addr_i))
      SEL_MASK:  rdata_o = mask;
      SEL_POL:   rdata_o = pol;
      SEL_TYPE:  rdata_o = typ;
      SEL_RAW:   rdata_o = raw;
      SEL_MSTAT: rdata_o = mstat;
      default:   rdata_o = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  AST_IRQ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_o == $past(|(raw & mask))); // R8
endmodule

// File: tb/tb_irq_polarity_ctrl.sv
module tb_irq_polarity_ctrl;
  localparam logic [31:0] POL_DEF  = 32'h3FF0_EFE0;
  localparam logic [31:0] TYPE_DEF = 32'h0000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = ~POL_DEF;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  irq_polarity_ctrl dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .addr_i(addr),
    .wdata_i(wdata), .we_i(we), .rdata_o(rdata), .irq_o(irq)
  );

  // entry: {select, write data, expected read-back}
  localparam logic [66:0] VEC [6] = '{
    {3'd0, 32'hA5A5_0F0F, 32'hA5A5_0F0F},
    {3'd1, 32'h1234_5678, 32'h1234_5678},
    {3'd2, 32'hFFFF_0000, 32'hFFFF_0000},
    {3'd0, 32'h0000_0000, 32'h0000_0000},
    {3'd1, 32'h0000_FFFF, 32'h0000_FFFF},
    {3'd2, 32'h00FF_00FF, 32'h00FF_00FF}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    step(1);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    step(3);
    rst_n = 1'b1;
    step(4);
    // R1 reset state
    rd(3'd0, v); chk("R1 mask", v, 32'h0);
    rd(3'd1, v); chk("R1 polarity", v, POL_DEF);
    rd(3'd2, v); chk("R1 type", v, TYPE_DEF);
    rd(3'd3, v); chk("R1 raw", v, 32'h0);
    rd(3'd4, v); chk("R1 masked", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R2 table-driven register read-back
    for (int k = 0; k < 6; k++) begin
      wr(VEC[k][66:64], VEC[k][63:32]);
      rd(VEC[k][66:64], v);
      chk("R2 readback", v, VEC[k][31:0]);
    end

    // now bits 0-7 rise edge, 8-15 high level, 16-23 fall edge, 24-31 low level
    src = 32'hFFFF_0000;
    step(4);
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd3, v); chk("R5 clear all", v, 32'h0);

    // R3 level high bit 8
    src[8] = 1'b1; step(2);
    rd(3'd3, v); chk("R3 not yet after two edges", v, 32'h0);
    step(1);
    rd(3'd3, v); chk("R3 level high set", v, 32'h0000_0100);
    rd(3'd4, v); chk("R9 masked off", v, 32'h0);
    step(1);
    chk("R9 irq off", {31'b0, irq}, 32'h0);
    src[8] = 1'b0; step(3);
    rd(3'd3, v); chk("R3 level high released", v, 32'h0);

    // R3 level low bit 24, R5 clear while active
    src[24] = 1'b0; step(3);
    rd(3'd3, v); chk("R3 level low set", v, 32'h0100_0000);
    wr(3'd3, 32'h0100_0000);
    rd(3'd3, v); chk("R5 level stays active", v, 32'h0100_0000);
    src[24] = 1'b1; step(3);
    rd(3'd3, v); chk("R3 level low released", v, 32'h0);

    // R4 rising edge bit 0, falling edge bit 16
    src[0] = 1'b1; step(3); src[0] = 1'b0; step(3);
    rd(3'd3, v); chk("R4 rising latched", v, 32'h0000_0001);
    src[16] = 1'b0; step(3); src[16] = 1'b1; step(3);
    rd(3'd3, v); chk("R4 falling latched", v, 32'h0001_0001);
    wr(3'd3, 32'h0);
    rd(3'd3, v); chk("R5 zero write no effect", v, 32'h0001_0001);
    wr(3'd3, 32'h0000_0001);
    rd(3'd3, v); chk("R5 clear bit 0", v, 32'h0001_0000);

    // R7 / R8 masking and output
    wr(3'd0, 32'h0001_0000);
    rd(3'd4, v); chk("R7 masked status", v, 32'h0001_0000);
    chk("R8 irq not yet", {31'b0, irq}, 32'h0);
    step(1);
    chk("R8 irq set", {31'b0, irq}, 32'h1);
    wr(3'd4, 32'h0);
    rd(3'd4, v); chk("R7 write ignored", v, 32'h0001_0000);
    rd(3'd0, v); chk("R7 mask unchanged", v, 32'h0001_0000);
    wr(3'd3, 32'h0001_0000);
    chk("R8 irq still high", {31'b0, irq}, 32'h1);
    step(1);
    chk("R8 irq cleared", {31'b0, irq}, 32'h0);

    // R6 edge and clear in the same cycle on bit 1
    src[1] = 1'b1; step(3); src[1] = 1'b0; step(3);
    rd(3'd3, v); chk("R4 bit 1 latched", v, 32'h0000_0002);
    src[1] = 1'b1; step(2);
    wr(3'd3, 32'h0000_0002);
    rd(3'd3, v); chk("R6 event wins over clear", v, 32'h0000_0002);
    wr(3'd3, 32'h0000_0002);
    rd(3'd3, v); chk("R6 later clear works", v, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule